// File: doc/BRIEF.md
# Serial Input Shift Register with Autopush

This block assembles a serial bit stream into words. Each accepted shift request moves one bit into a 32-bit shift register and raises a saturating bit counter. When autopush is switched on and the counter, after the shift, reaches the programmed threshold, the shifter hands the assembled word to a small receive FIFO. Handing off a word zeroes both the register and the counter. The host reads words from the FIFO with a show-ahead read port and can see its full and empty flags.

Autopush can be switched on or off at any cycle. With autopush off, the counter keeps counting and is not reset when autopush is switched back on. A register that was left with eight or more counted bits therefore pushes on the very next shift. Every later word is then misaligned by one bit: it holds the last seven bits of one byte and the first bit of the next. The clear input zeroes the register and the counter so that the host can restore byte alignment, for example between a transmitted byte and a received one.

When a push is due but the FIFO is full, the shift is not accepted. The caller holds its request until space frees, so no bit is lost.

Top module: `inshift_autopush`

## Requirements
- R1: After synchronous reset the FIFO is empty (fifo_empty=1, fifo_full=0) and shift_ready is 1.
- R2: While autopush_en is 0, shifts never write the FIFO, and fifo_empty stays 1 when the FIFO was empty.
- R3: With shift_left=1 and a zero counter, the shift that brings the counter to push_thresh pushes the low 8 bits of the register. The newest bit is at bit 0, so for threshold 8 a byte sent MSB first arrives unchanged.
- R4: A push zeroes the register and the counter, so back-to-back bytes each arrive intact.
- R5: The counter advances during shifts with autopush off. If autopush is enabled with the count at 8 or more, the next single shift pushes. Later words then each hold bits [6:0] of one byte followed by bit 7 of the next.
- R6: clear zeroes the register and the counter. It takes priority over a shift in the same cycle, which is dropped, and it restores byte alignment.
- R7: The counter saturates at 32 and never wraps. After 70 shifts with autopush off, enabling autopush makes the next shift push.
- R8: When a push is due and the FIFO is full, shift_ready is 0 and the shift is not taken. After a read frees an entry the held bit is accepted, and the word it completes is correct.
- R9: The FIFO holds 4 words and returns them in push order. fifo_full is 1 at 4 entries, and the two flags are never 1 together.
- R10: With shift_left=0 each bit enters at register bit 31 and the pushed word is bits [31:24]. A byte sent LSB first at threshold 8 therefore arrives unchanged.
- R11: rd_en while the FIFO is empty has no effect. The flags do not change and later words still arrive correctly.
- R12: The threshold is taken from push_thresh. With push_thresh=4 and shift_left=1, four shifts push a word whose low nibble holds those bits, first bit at bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_en | input | 1 | Request to shift one bit in |
| shift_bit | input | 1 | Bit to shift in |
| shift_left | input | 1 | 1: newest bit enters at bit 0; 0: newest bit enters at bit 31 |
| autopush_en | input | 1 | Enables automatic push at the threshold |
| push_thresh | input | 6 | Bit count that triggers a push |
| clear | input | 1 | Zeroes the shift register and the counter |
| rd_en | input | 1 | Pops the FIFO head |
| rd_data | output | 8 | FIFO head word (show-ahead) |
| fifo_full | output | 1 | FIFO holds 4 words |
| fifo_empty | output | 1 | FIFO holds no word |
| shift_ready | output | 1 | A shift request in this cycle would be taken |

## Verification
The checker watches the FIFO on every cycle. The flags are never both set, a full FIFO stays full until it is read, and the head word holds while nothing pops. A stall may appear only with a full FIFO or a clear, and with autopush off an empty FIFO stays empty. Only the bench scenarios show the word contents: the byte sweep in both directions, the stale-count one-bit misalignment and its removal by clear, counter saturation, the threshold setting and the stalled bit completing the right word.

// File: rtl/isr_pkg.sv
package isr_pkg;
    localparam int REG_W      = 32;
    localparam int CNT_W      = 6;
    localparam int CNT_MAX    = 32;
    localparam int WORD_W     = 8;
    localparam int FIFO_DEPTH = 4;

    typedef enum logic {
        DIR_RIGHT = 1'b0,
        DIR_LEFT  = 1'b1
    } shift_dir_e;

    typedef struct packed {
        logic [REG_W-1:0] data;
        logic [CNT_W-1:0] count;
    } isr_state_t;

    function automatic logic [CNT_W-1:0] count_step(input logic [CNT_W-1:0] c);
        if (c >= CNT_W'(CNT_MAX)) return CNT_W'(CNT_MAX);
        return c + 1'b1;
    endfunction

    function automatic logic [REG_W-1:0] shift_in(input logic [REG_W-1:0] d,
                                                  input logic b,
                                                  input shift_dir_e dir);
        if (dir == DIR_LEFT) return {d[REG_W-2:0], b};
        return {b, d[REG_W-1:1]};
    endfunction

    function automatic logic [WORD_W-1:0] take_word(input logic [REG_W-1:0] d,
                                                    input shift_dir_e dir);
        if (dir == DIR_LEFT) return d[WORD_W-1:0];
        return d[REG_W-1 -: WORD_W];
    endfunction
endpackage

// File: rtl/isr_shifter.sv
module isr_shifter
    import isr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic             bit_in,
    input  shift_dir_e       dir,
    input  logic             clear,
    input  logic             push,
    output logic [REG_W-1:0] next_data,
    output logic [CNT_W-1:0] next_count
);
    isr_state_t st;

    always_comb begin
        next_data  = shift_in(st.data, bit_in, dir);
        next_count = count_step(st.count);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            st <= '0;
        end else if (take) begin
            if (push) begin
                st <= '0;
            end else begin
                st.data  <= next_data;
                st.count <= next_count;
            end
        end
    end
endmodule

// File: rtl/isr_fifo.sv
module isr_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             full,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [CW-1:0]    level;
    logic             do_wr, do_rd;

    assign full    = (level == CW'(DEPTH));
    assign empty   = (level == '0);
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign rd_data = mem[rp];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        if (p == AW'(DEPTH - 1)) return '0;
        return p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_wr) wp <= bump(wp);
            if (do_rd) rp <= bump(rp);
            if (do_wr && !do_rd) level <= level + 1'b1;
            else if (do_rd && !do_wr) level <= level - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= wr_data;
    end
endmodule

// File: rtl/inshift_autopush.sv
module inshift_autopush
    import isr_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              shift_bit,
    input  logic              shift_left,
    input  logic              autopush_en,
    input  logic [CNT_W-1:0]  push_thresh,
    input  logic              clear,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    output logic              fifo_full,
    output logic              fifo_empty,
    output logic              shift_ready
);
    shift_dir_e        dir;
    logic [REG_W-1:0]  nxt_data;
    logic [CNT_W-1:0]  nxt_count;
    logic              push_due, take, push;

    assign dir         = shift_dir_e'(shift_left);
    assign push_due    = autopush_en && (nxt_count >= push_thresh);
    assign shift_ready = !clear && !(push_due && fifo_full);
    assign take        = shift_en && shift_ready;
    assign push        = take && push_due;

    isr_shifter u_shift (
        .clk        (clk),
        .rst        (rst),
        .take       (take),
        .bit_in     (shift_bit),
        .dir        (dir),
        .clear      (clear),
        .push       (push),
        .next_data  (nxt_data),
        .next_count (nxt_count)
    );

    isr_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (push),
        .wr_data (take_word(nxt_data, dir)),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .full    (fifo_full),
        .empty   (fifo_empty)
    );
endmodule

// File: rtl/isr_checker.sv
module isr_checker (
    input logic       clk,
    input logic       rst,
    input logic       autopush_en,
    input logic       clear,
    input logic       rd_en,
    input logic [7:0] rd_data,
    input logic       fifo_full,
    input logic       fifo_empty,
    input logic       shift_ready
);
    a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(fifo_full && fifo_empty));

    a_r9_full_holds: assert property (@(posedge clk) disable iff (rst)
        (fifo_full && !rd_en) |=> fifo_full);

    a_r9_head_stable: assert property (@(posedge clk) disable iff (rst)
        (!fifo_empty && !rd_en) |=> $stable(rd_data));

    a_r8_stall_only_when_full: assert property (@(posedge clk) disable iff (rst)
        !shift_ready |-> (fifo_full || clear));

    a_r2_no_push_when_off: assert property (@(posedge clk) disable iff (rst)
        (!autopush_en && fifo_empty) |=> fifo_empty);
endmodule

bind inshift_autopush isr_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .autopush_en (autopush_en),
    .clear       (clear),
    .rd_en       (rd_en),
    .rd_data     (rd_data),
    .fifo_full   (fifo_full),
    .fifo_empty  (fifo_empty),
    .shift_ready (shift_ready)
);

// File: tb/tb_inshift_autopush.sv
module tb_inshift_autopush;
    localparam int CLK_PERIOD = 10;

    logic       clk = 0;
    logic       rst = 1;
    logic       shift_en = 0, shift_bit = 0, shift_left = 1;
    logic       autopush_en = 0, clear = 0, rd_en = 0;
    logic [5:0] push_thresh = 6'd8;
    logic [7:0] rd_data;
    logic       fifo_full, fifo_empty, shift_ready;

    int checks = 0, failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    inshift_autopush dut (
        .clk(clk), .rst(rst), .shift_en(shift_en), .shift_bit(shift_bit),
        .shift_left(shift_left), .autopush_en(autopush_en),
        .push_thresh(push_thresh), .clear(clear), .rd_en(rd_en),
        .rd_data(rd_data), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
        .shift_ready(shift_ready)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic shift_one(input logic b);
        int guard = 0;
        shift_en = 1; shift_bit = b;
        #1;
        while (!shift_ready && guard < 100) begin
            @(negedge clk); #1; guard++;
        end
        @(negedge clk);
        shift_en = 0;
    endtask

    task automatic send_msb(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) shift_one(v[i]);
    endtask

    task automatic send_lsb(input logic [7:0] v);
        for (int i = 0; i < 8; i++) shift_one(v[i]);
    endtask

    task automatic pop(input string req, input logic [7:0] exp);
        chk(req, {31'd0, fifo_empty}, 32'd0);
        chk(req, {24'd0, rd_data}, {24'd0, exp});
        rd_en = 1;
        @(negedge clk);
        rd_en = 0;
    endtask

    task automatic do_clear();
        clear = 1;
        @(negedge clk);
        clear = 0;
    endtask

    initial begin
        int guard = 0;
        #(CLK_PERIOD * 190000);
        $display("FAIL watchdog actual=running expected=finished");
        failures++;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] seq [4];
        @(negedge clk); @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 empty", {31'd0, fifo_empty}, 1);
        chk("R1 full", {31'd0, fifo_full}, 0);
        chk("R1 ready", {31'd0, shift_ready}, 1);

        // R3 sweep of all bytes, left shift, threshold 8
        autopush_en = 1;
        for (int v = 0; v < 256; v++) begin
            send_msb(8'(v));
            pop("R3 byte", 8'(v));
        end

        // R4 back-to-back words, R9 order and full
        seq[0] = 8'h11; seq[1] = 8'hC3; seq[2] = 8'h5A; seq[3] = 8'hF0;
        for (int i = 0; i < 4; i++) send_msb(seq[i]);
        chk("R9 full at 4", {31'd0, fifo_full}, 1);
        for (int i = 0; i < 4; i++) pop("R4 R9 order", seq[i]);
        chk("R9 empty after drain", {31'd0, fifo_empty}, 1);

        // R8 stall on full
        for (int i = 0; i < 4; i++) send_msb(8'h20 + 8'(i));
        for (int i = 7; i >= 1; i--) shift_one(1'b1 ^ (i == 3));
        shift_en = 1; shift_bit = 0;
        #1;
        chk("R8 stalled", {31'd0, shift_ready}, 0);
        repeat (3) @(negedge clk);
        chk("R8 still full", {31'd0, fifo_full}, 1);
        rd_en = 1;
        @(negedge clk);
        rd_en = 0;
        #1;
        chk("R8 ready after read", {31'd0, shift_ready}, 1);
        @(negedge clk);
        shift_en = 0;
        chk("R8 full again", {31'd0, fifo_full}, 1);
        for (int i = 1; i < 4; i++) pop("R8 queued", 8'h20 + 8'(i));
        pop("R8 held bit word", 8'b1111_0110);

        // R2 autopush off
        autopush_en = 0;
        do_clear();
        for (int i = 0; i < 16; i++) shift_one(1'b1);
        chk("R2 no push", {31'd0, fifo_empty}, 1);

        // R5 stale count misalignment
        do_clear();
        send_msb(8'hED);
        autopush_en = 1;
        seq[0] = 8'hED; seq[1] = 8'hFF; seq[2] = 8'h8B; seq[3] = 8'h00;
        for (int i = 1; i < 4; i++) begin
            shift_one(seq[i][7]);
            pop("R5 misaligned", {seq[i-1][6:0], seq[i][7]});
            for (int j = 6; j >= 0; j--) shift_one(seq[i][j]);
        end
        chk("R5 no extra word", {31'd0, fifo_empty}, 1);
        // R6 clear restores alignment
        do_clear();
        send_msb(8'h3C);
        pop("R6 realigned", 8'h3C);

        // R6 clear beats simultaneous shift
        shift_one(1); shift_one(0); shift_one(1);
        clear = 1; shift_en = 1; shift_bit = 1;
        @(negedge clk);
        clear = 0; shift_en = 0;
        for (int j = 7; j >= 1; j--) shift_one(8'h96 >> j);
        chk("R6 no early push", {31'd0, fifo_empty}, 1);
        shift_one(0);
        pop("R6 dropped shift", 8'h96);

        // R7 saturation
        autopush_en = 0;
        for (int i = 0; i < 70; i++) shift_one(1'b1);
        autopush_en = 1;
        shift_one(1'b0);
        pop("R7 saturated push", 8'hFE);

        // R11 read on empty
        rd_en = 1;
        @(negedge clk);
        rd_en = 0;
        chk("R11 empty kept", {31'd0, fifo_empty}, 1);
        chk("R11 full kept", {31'd0, fifo_full}, 0);
        send_msb(8'h69);
        pop("R11 later word", 8'h69);

        // R10 right shift
        shift_left = 0;
        for (int v = 0; v < 256; v += 17) begin
            send_lsb(8'(v));
            pop("R10 right", 8'(v));
        end
        shift_left = 1;

        // R12 threshold 4
        push_thresh = 6'd4;
        shift_one(1); shift_one(0); shift_one(1); shift_one(1);
        pop("R12 nibble", 8'h0B);
        push_thresh = 6'd8;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule